// File: doc/BRIEF.md
# Self-Timed EEPROM Byte Access Controller

This block sits on the host side of a parallel, self-timed EEPROM. It takes byte-write and byte-read requests over a valid/ready handshake. For each request it generates the chip-select, output-gate and write-strobe sequence on the memory pins. All bus timing is counted in clock cycles set by parameters.

After a write strobe the device programs the byte on its own, and the controller does not wait for a fixed worst-case time. In the default mode it reads the same address again and again. While programming is in progress the device returns bit 7 inverted, so the write is finished in the poll whose bit 7 equals the bit 7 that was written. In the alternative mode, chosen by the parameter `USE_RDY_BUSY`, the controller samples the device's ready/busy line instead. A watchdog limits the wait. If completion is not seen in time, the response carries a timeout flag and the controller returns to idle.

The state machine has eight states:

- `ST_IDLE`: ready for a request.
- `ST_WR_SETUP`: selects the device and puts the address and data on the bus.
- `ST_WR_STROBE`: holds the write strobe low.
- `ST_WR_HOLD`: strobe high, data still driven.
- `ST_WAIT`: gap between completion checks.
- `ST_POLL`: poll read.
- `ST_RD_ACCESS`: read access time.
- `ST_RESP`: one-cycle response.

The transitions are:

- IDLE→WR_SETUP on a write accept.
- IDLE→RD_ACCESS on a read accept.
- WR_SETUP→WR_STROBE after one cycle.
- WR_STROBE→WR_HOLD after `WE_LOW_CYC` cycles.
- WR_HOLD→WAIT after one cycle.
- At the end of a `POLL_GAP_CYC` wait:
  - WAIT→POLL in poll mode.
  - WAIT→RESP if the device is ready (ready/busy mode) or the watchdog has expired.
  - WAIT→WAIT otherwise, which restarts the gap.
- POLL→RESP on a bit-7 match after `ACCESS_CYC` cycles, otherwise POLL→WAIT.
- RD_ACCESS→RESP after `ACCESS_CYC` cycles.
- RESP→IDLE after one cycle.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0, and `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1.
- R2: Every write request produces exactly one low pulse on `mem_we_n`, lasting exactly `WE_LOW_CYC` cycles. Throughout the pulse `mem_ce_n` is 0, `mem_oe_n` is 1 and `mem_dq_oe` is 1.
- R3: `mem_addr` holds the request address from before the strobe falls until after it rises. `mem_dq_out` holds the write data through the strobe and for one cycle after it. As a result, a later read of that address returns the written byte.
- R4: In poll mode (`USE_RDY_BUSY`=0), a write completes only after a poll read of the written address returns a bit 7 (`mem_dq_in[7]`) equal to bit 7 of the write data. Poll reads repeat every `POLL_GAP_CYC`+`ACCESS_CYC` cycles.
- R5: In ready/busy mode (`USE_RDY_BUSY`=1), a write completes at the first end-of-gap check that samples `mem_rdy`=1. Checks repeat every `POLL_GAP_CYC` cycles.
- R6: If the watchdog has counted `TIMEOUT_CYC` waiting cycles at an end-of-gap check and completion has not been seen, the response is given with `rsp_timeout`=1 and the controller returns to idle. A successful completion gives `rsp_timeout`=0.
- R7: A request is accepted only when `req_ready` is 1, which happens in idle only. `req_valid` asserted at any other time has no effect on the memory or on the number of responses. Each accepted request gets exactly one response.
- R8: For a read accepted at clock edge k, `mem_ce_n` and `mem_oe_n` are both 0 for `ACCESS_CYC` cycles. `mem_dq_in` is captured at edge k+`ACCESS_CYC`. `rsp_valid` is high, with the captured byte on `rsp_rdata`, in the cycle that follows that edge.
- R9: `rsp_valid` is a one-cycle pulse, and `req_ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_write | input | 1 | 1 for byte write, 0 for byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Data of the last read |
| rsp_timeout | output | 1 | Write completion not seen in time (valid with rsp_valid) |
| mem_ce_n | output | 1 | Device select, active low |
| mem_oe_n | output | 1 | Device output gate, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Device address |
| mem_dq_out | output | 8 | Data toward the device |
| mem_dq_oe | output | 1 | Host drives the data bus |
| mem_dq_in | input | 8 | Data from the device |
| mem_rdy | input | 1 | Device ready (1) or busy (0) |

## Verification
A read response is due exactly `ACCESS_CYC` edges after the accepting edge. The bench records the accepting edge number and compares it with the edge number seen on the falling edge where `rsp_valid` is high.

A write response depends on how long the device model stays busy. The bench checks that the response comes strictly after the model's completion edge and no more than two check rounds later. A timed-out write is bounded by `TIMEOUT_CYC` below and by the strobe overhead plus two rounds above.

The strobe width is counted on falling edges. All sampling happens on the falling clock edge, away from the edges where the design updates.

// File: rtl/eewc_pkg.sv
package eewc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_WAIT,
        ST_POLL,
        ST_RD_ACCESS,
        ST_RESP
    } eewc_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/eewc_phase_timer.sv
module eewc_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/eewc_watchdog.sv
module eewc_watchdog #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIM);

    // R6: expiry only ever follows counted waiting cycles
    assert_wd_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(run));

endmodule

// File: rtl/eewc_done_detect.sv
module eewc_done_detect #(
    parameter bit USE_RDY_BUSY = 1'b0
) (
    input  logic [7:0] din,
    input  logic       rdy,
    input  logic       wbit7,
    output logic       done
);
    generate
        if (USE_RDY_BUSY) begin : g_rdy
            logic unused_poll;
            assign unused_poll = ^{din, wbit7};
            assign done = rdy;
        end else begin : g_poll
            logic unused_rdy;
            assign unused_rdy = rdy;
            assign done = (din[7] == wbit7);
        end
    endgenerate

endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
    import eewc_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int WE_LOW_CYC   = 4,
    parameter int POLL_GAP_CYC = 4,
    parameter int ACCESS_CYC   = 3,
    parameter int TIMEOUT_CYC  = 200000,
    parameter bit USE_RDY_BUSY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    output logic              rsp_timeout,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [7:0]        mem_dq_in,
    input  logic              mem_rdy
);
    localparam int PH_MAX = max3(WE_LOW_CYC, POLL_GAP_CYC, ACCESS_CYC);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] PH_STROBE = PH_W'(WE_LOW_CYC - 1);
    localparam logic [PH_W-1:0] PH_GAP    = PH_W'(POLL_GAP_CYC - 1);
    localparam logic [PH_W-1:0] PH_ACC    = PH_W'(ACCESS_CYC - 1);

    eewc_state_e state_q, state_d;
    logic [PH_W-1:0]   ph_cnt;
    logic              ph_restart, ph_clr;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q, rd_q;
    logic              to_q, fin_timeout;
    logic              accept, wd_run, wd_expired, dev_done;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign wd_run = (state_q == ST_WAIT) || (state_q == ST_POLL);

    eewc_phase_timer #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .cnt   (ph_cnt)
    );

    eewc_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .run     (wd_run),
        .expired (wd_expired)
    );

    eewc_done_detect #(.USE_RDY_BUSY(USE_RDY_BUSY)) u_done (
        .din   (mem_dq_in),
        .rdy   (mem_rdy),
        .wbit7 (wdata_q[7]),
        .done  (dev_done)
    );

    // next-state selection
    always_comb begin
        state_d     = state_q;
        ph_restart  = 1'b0;
        fin_timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            end
            ST_WR_SETUP:  state_d = ST_WR_STROBE;
            ST_WR_STROBE: if (ph_cnt == PH_STROBE) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   state_d = ST_WAIT;
            ST_WAIT: begin
                if (ph_cnt == PH_GAP) begin
                    if (USE_RDY_BUSY && dev_done) begin
                        state_d = ST_RESP;
                    end else if (wd_expired) begin
                        state_d     = ST_RESP;
                        fin_timeout = 1'b1;
                    end else if (USE_RDY_BUSY) begin
                        ph_restart = 1'b1;
                    end else begin
                        state_d = ST_POLL;
                    end
                end
            end
            ST_POLL: begin
                if (ph_cnt == PH_ACC) state_d = dev_done ? ST_RESP : ST_WAIT;
            end
            ST_RD_ACCESS: if (ph_cnt == PH_ACC) state_d = ST_RESP;
            ST_RESP:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign ph_clr = ph_restart || (state_d != state_q);

    // state and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                to_q    <= 1'b0;
            end
            if (fin_timeout) to_q <= 1'b1;
            if (state_q == ST_RD_ACCESS && ph_cnt == PH_ACC) rd_q <= mem_dq_in;
        end
    end

    // pin and handshake outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_WR_SETUP:  begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_STROBE: begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_HOLD:   begin mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WAIT:      ;
            ST_POLL:      begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
            ST_RD_ACCESS: begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
            ST_RESP:      rsp_valid = 1'b1;
            default:      ;
        endcase
    end

    assign mem_addr    = addr_q;
    assign mem_dq_out  = wdata_q;
    assign rsp_rdata   = rd_q;
    assign rsp_timeout = rsp_valid && to_q;

    assert_strobe_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    assert_addr_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && !mem_ce_n && mem_dq_oe));

    assert_timeout_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> (rsp_valid && $past(state_q) == ST_WAIT));

    assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    assert_read_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: tb/eeprom_wr_ctrl_tb.sv
module eewc_dev_model #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    input  int            busy_len,
    input  int            cyc,
    output logic [7:0]    dq_out,
    output logic          rdy,
    output int            fin_cyc
);
    logic [7:0]    mem [1<<AW];
    logic [AW-1:0] lat_addr;
    logic [7:0]    pend;
    logic          we_prev;
    int            busy_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= 8'h00;
            we_prev  <= 1'b1;
            busy_cnt <= 0;
            fin_cyc  <= 0;
            lat_addr <= '0;
            pend     <= '0;
        end else begin
            we_prev <= we_n;
            if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
                if (busy_cnt == 1) begin
                    mem[lat_addr] <= pend;
                    fin_cyc       <= cyc;
                end
            end
            if (we_prev && !we_n && !ce_n) lat_addr <= addr;
            if (!we_prev && we_n && !ce_n) begin
                pend <= dq_in;
                if (busy_len == 0) begin
                    mem[lat_addr] <= dq_in;
                    fin_cyc       <= cyc;
                end else begin
                    busy_cnt <= busy_len;
                end
            end
        end
    end

    assign rdy = (busy_cnt == 0);
    always_comb begin
        if (ce_n || oe_n) dq_out = 8'h00;
        else if (busy_cnt != 0 && addr == lat_addr) dq_out = {~pend[7], 7'h2A};
        else dq_out = mem[addr];
    end
endmodule

module eeprom_wr_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int WEL = 3;
    localparam int GAP = 2;
    localparam int ACC = 2;
    localparam int TO  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic          req_valid [2];
    logic          req_ready [2];
    logic          req_write [2];
    logic [AW-1:0] req_addr  [2];
    logic [7:0]    req_wdata [2];
    logic          rsp_valid [2];
    logic [7:0]    rsp_rdata [2];
    logic          rsp_timeout [2];
    logic          ce_n [2], oe_n [2], we_n [2], dq_oe [2], rdy [2];
    logic [AW-1:0] maddr [2];
    logic [7:0]    dq_o [2], dq_i [2];
    int            busy_len [2];
    int            fin_cyc [2];

    int n_chk = 0, n_bad = 0;
    int mon_chk [2], mon_bad [2], n_acc [2], n_rsp [2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    for (genvar g = 0; g < 2; g++) begin : g_dut
        eeprom_wr_ctrl #(
            .ADDR_W(AW), .WE_LOW_CYC(WEL), .POLL_GAP_CYC(GAP),
            .ACCESS_CYC(ACC), .TIMEOUT_CYC(TO), .USE_RDY_BUSY(g == 1)
        ) u_dut (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid[g]), .req_ready(req_ready[g]),
            .req_write(req_write[g]), .req_addr(req_addr[g]), .req_wdata(req_wdata[g]),
            .rsp_valid(rsp_valid[g]), .rsp_rdata(rsp_rdata[g]), .rsp_timeout(rsp_timeout[g]),
            .mem_ce_n(ce_n[g]), .mem_oe_n(oe_n[g]), .mem_we_n(we_n[g]),
            .mem_addr(maddr[g]), .mem_dq_out(dq_o[g]), .mem_dq_oe(dq_oe[g]),
            .mem_dq_in(dq_i[g]), .mem_rdy(rdy[g])
        );

        eewc_dev_model #(.AW(AW)) u_model (
            .clk(clk), .rst_n(rst_n), .ce_n(ce_n[g]), .oe_n(oe_n[g]), .we_n(we_n[g]),
            .addr(maddr[g]), .dq_in(dq_o[g]), .busy_len(busy_len[g]), .cyc(cyc),
            .dq_out(dq_i[g]), .rdy(rdy[g]), .fin_cyc(fin_cyc[g])
        );

        // strobe width and control levels, handshake counting (R2, R7)
        int run = 0;
        initial begin
            mon_chk[g] = 0; mon_bad[g] = 0; n_acc[g] = 0; n_rsp[g] = 0;
        end
        always @(negedge clk) begin
            if (rst_n) begin
                if (req_valid[g] && req_ready[g]) n_acc[g]++;
                if (rsp_valid[g]) n_rsp[g]++;
                if (!we_n[g]) begin
                    run++;
                    mon_chk[g]++;
                    if (ce_n[g] || !oe_n[g] || !dq_oe[g]) begin
                        mon_bad[g]++;
                        $display("FAIL R2 dut%0d ctl during strobe ce_n=%0d oe_n=%0d expected 0/1", g, ce_n[g], oe_n[g]);
                    end
                end else if (run > 0) begin
                    mon_chk[g]++;
                    if (run != WEL) begin
                        mon_bad[g]++;
                        $display("FAIL R2 dut%0d strobe width actual=%0d expected=%0d", g, run, WEL);
                    end
                    run = 0;
                end
            end
        end
    end

    task automatic do_write(input int d, input int a, input logic [7:0] v,
                            input int busy, input bit exp_to, input bit poke);
        int acc, n;
        busy_len[d] = busy;
        @(negedge clk);
        req_valid[d] = 1'b1; req_write[d] = 1'b1;
        req_addr[d] = AW'(a); req_wdata[d] = v;
        @(negedge clk);
        req_valid[d] = 1'b0;
        acc = cyc;
        if (poke) begin
            req_valid[d] = 1'b1; req_addr[d] = AW'(a ^ 1); req_wdata[d] = ~v;
            check(req_ready[d] == 1'b0, "R7 ready low while busy", req_ready[d], 0);
            @(negedge clk);
            check(req_ready[d] == 1'b0, "R7 ready low while busy", req_ready[d], 0);
            req_valid[d] = 1'b0;
        end
        n = 0;
        while (!rsp_valid[d] && n < 5000) begin @(negedge clk); n++; end
        check(rsp_timeout[d] == exp_to, exp_to ? "R6 timeout flag" : "R6 no timeout flag",
              rsp_timeout[d], exp_to);
        if (exp_to) begin
            check(cyc - acc >= TO && cyc - acc <= TO + WEL + 2*(GAP+ACC) + 6,
                  "R6 timeout latency", cyc - acc, TO);
        end else begin
            check(cyc > fin_cyc[d] && cyc <= fin_cyc[d] + 2*(GAP+ACC) + 4,
                  d == 0 ? "R4 poll completion timing" : "R5 ready completion timing",
                  cyc, fin_cyc[d]);
        end
        @(negedge clk);
        check(!rsp_valid[d] && req_ready[d], "R9 single pulse then ready",
              {rsp_valid[d], req_ready[d]}, 1);
        if (exp_to) begin
            n = 0;
            while (!rdy[d] && n < 500) begin @(negedge clk); n++; end
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic do_read(input int d, input int a, input logic [7:0] exp, input string req);
        int acc, n;
        @(negedge clk);
        req_valid[d] = 1'b1; req_write[d] = 1'b0; req_addr[d] = AW'(a);
        @(negedge clk);
        req_valid[d] = 1'b0;
        acc = cyc;
        n = 0;
        while (!rsp_valid[d] && n < 5000) begin @(negedge clk); n++; end
        check(cyc - acc == ACC, "R8 read latency", cyc - acc, ACC);
        check(rsp_rdata[d] == exp, req, rsp_rdata[d], exp);
        @(negedge clk);
        check(!rsp_valid[d] && req_ready[d], "R9 single pulse then ready",
              {rsp_valid[d], req_ready[d]}, 1);
    endtask

    function automatic logic [7:0] pat(input int d, input int a);
        return 8'((a * 37 + d * 11 + 5) ^ (a << 5));
    endfunction

    task automatic finish_run();
        int t, b;
        t = n_chk + mon_chk[0] + mon_chk[1];
        b = n_bad + mon_bad[0] + mon_bad[1];
        $display("test done: total=%0d bad=%0d", t, b);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            req_valid[d] = 1'b0; req_write[d] = 1'b0;
            req_addr[d] = '0; req_wdata[d] = '0; busy_len[d] = 0;
        end
        repeat (3) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check(req_ready[d] && !rsp_valid[d] && ce_n[d] && oe_n[d] && we_n[d],
                  "R1 reset state", {req_ready[d], rsp_valid[d], ce_n[d], oe_n[d], we_n[d]}, 5'b10111);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check(req_ready[d] && we_n[d] && ce_n[d], "R1 after reset", req_ready[d], 1);
        end

        for (int d = 0; d < 2; d++) begin
            // R3 R4 R5: every address, bit 7 both ways, busy 0..12 cycles
            for (int a = 0; a < (1 << AW); a++) begin
                do_write(d, a, pat(d, a), (a % 5) * 3, 1'b0, 1'b0);
            end
            for (int a = 0; a < (1 << AW); a++) begin
                do_read(d, a, pat(d, a), "R3 R8 read-back data");
            end
            // R7: request poked while busy is ignored
            do_write(d, 6, 8'hC3, 12, 1'b0, 1'b1);
            do_read(d, 7, pat(d, 7), "R7 poked address untouched");
            do_read(d, 6, 8'hC3, "R3 read-back after poke");
            // R6: device never finishes within the watchdog limit
            do_write(d, 9, 8'h1E, 80, 1'b1, 1'b0);
            do_write(d, 10, 8'h80, 4, 1'b0, 1'b0);
            do_read(d, 10, 8'h80, "R6 idle again after timeout");
            check(n_acc[d] == n_rsp[d], "R7 one response per accept", n_rsp[d], n_acc[d]);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule